// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block takes one control-transfer instruction of a small 8-bit RISC microcontroller (a 16-bit first word, plus a second word when the encoding needs one) and works out where execution goes next. It handles these instruction forms in one path:

- short relative jumps and calls;
- branches that test one bit of the status byte;
- long absolute jumps and calls that span two words;
- jumps and calls through a 16-bit pointer held as two bytes.

Each result is wrapped to the program-memory size. For calls, the block also gives a push request and the return address. It raises a flag when the fetch side must consume the second word.

The instruction enters as one beat on a valid/ready input, together with the current PC, the status byte and the two pointer bytes. The result leaves one cycle later as one beat on a valid/ready output. The input is ready whenever the output register is empty, or is being emptied in the same cycle. While the output is valid and not accepted, every output field holds its value. The push request is part of the result beat: it is seen once for each accepted beat. The program-memory size is 2^`PMEM_AW` words, with `PMEM_AW` at most 22. PC fields are 22 bits wide.

Top module: `cf_next_pc`

## Requirements
- R1: Word0 bits 15:12 = 1100 is a relative jump and 1101 a relative call; the target is PC+1 plus the sign-extended word0 bits 11:0.
- R2: Word0 bits 15:10 = 111100 branches if status bit word0[2:0] is 1, and 111101 branches if it is 0. When taken, the target is PC+1 plus the sign-extended word0 bits 9:3. When not taken, the result is PC+1.
- R3: A first word with bits 15:9 = 1001010 and bits 3:1 = 110 is an absolute jump; with bits 3:1 = 111 it is an absolute call. The target is {word0[8:4], word0[0], word1}. Both forms set the two-word flag.
- R4: Word0 = 0x9409 is an indirect jump and 0x9509 an indirect call. The target is PC with bits 15:0 replaced by {ptr_hi, ptr_lo}.
- R5: Relative, absolute and indirect calls set the push flag. The return address is PC+1, or PC+2 for the absolute call. Every other instruction has the push flag clear and a return address of 0.
- R6: Any other word0 gives PC+1, with the push flag and the two-word flag clear.
- R7: Every next-PC and return-address value is reduced modulo 2^PMEM_AW, so the bits above PMEM_AW-1 are zero.
- R8: in_ready = !out_valid || out_ready. An accepted beat is presented on the output on the next cycle.
- R9: While out_valid is high and out_ready is low, out_valid and all output fields stay unchanged.
- R10: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_pc | input | 22 | PC of the instruction |
| in_word0 | input | 16 | First instruction word |
| in_word1 | input | 16 | Second instruction word (used by absolute forms) |
| in_status | input | 8 | Status byte |
| in_ptr_lo | input | 8 | Pointer low byte |
| in_ptr_hi | input | 8 | Pointer high byte |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result beat accepted |
| out_next_pc | output | 22 | Next PC, wrapped |
| out_push | output | 1 | Return address must be pushed |
| out_ret_addr | output | 22 | Return address, wrapped (0 when no push) |
| out_two_word | output | 1 | Fetch must consume the second word |

## Verification
Random beats mix the following kinds of first word:

- Every recognised opcode class, which tells apart the decode boundaries between neighbouring patterns, such as the absolute encodings, the two indirect codes and the unrecognised words around them.
- Random PCs that carry bits above the memory size, which separate correct wrapping from plain 22-bit arithmetic.
- Random status bytes against each bit index and polarity, which tell a taken branch from an untaken one.

Directed beats cover the following corners:

- the extreme offsets of both relative forms;
- jumps backwards from PC 0;
- absolute targets whose high bits fall outside memory;
- indirect targets that must keep the upper PC bits.

Random stall lengths on the output exercise the hold and ready rules.

// File: rtl/cf_pkg.sv
package cf_pkg;

  // Architectural program-counter width in words
  localparam int PC_W = 22;

  typedef enum logic [3:0] {
    K_SEQ,
    K_REL_JUMP,
    K_REL_CALL,
    K_BR_SET,
    K_BR_CLR,
    K_ABS_JUMP,
    K_ABS_CALL,
    K_IND_JUMP,
    K_IND_CALL
  } cf_kind_e;

  typedef struct packed {
    logic [PC_W-1:0] next_pc;
    logic            push;
    logic [PC_W-1:0] ret_addr;
    logic            two_word;
  } cf_result_t;

endpackage

// File: rtl/cf_decode.sv
module cf_decode
  import cf_pkg::*;
(
  input  logic [15:0] word0,
  output cf_kind_e    kind
);

  localparam logic [15:0] IND_JUMP_CODE = 16'h9409;
  localparam logic [15:0] IND_CALL_CODE = 16'h9509;

  logic is_abs_group;
  assign is_abs_group = (word0[15:9] == 7'b1001010);

  always_comb begin
    kind = K_SEQ;
    if (word0[15:12] == 4'b1100)
      kind = K_REL_JUMP;
    else if (word0[15:12] == 4'b1101)
      kind = K_REL_CALL;
    else if (word0[15:10] == 6'b111100)
      kind = K_BR_SET;
    else if (word0[15:10] == 6'b111101)
      kind = K_BR_CLR;
    else if (word0 == IND_JUMP_CODE)
      kind = K_IND_JUMP;
    else if (word0 == IND_CALL_CODE)
      kind = K_IND_CALL;
    else if (is_abs_group && word0[3:1] == 3'b110)
      kind = K_ABS_JUMP;
    else if (is_abs_group && word0[3:1] == 3'b111)
      kind = K_ABS_CALL;
  end

endmodule

// File: rtl/cf_target.sv
module cf_target
  import cf_pkg::*;
#(
  parameter int PMEM_AW = 20
) (
  input  cf_kind_e        kind,
  input  logic [PC_W-1:0] pc,
  input  logic [15:0]     word0,
  input  logic [15:0]     word1,
  input  logic [7:0]      status,
  input  logic [7:0]      ptr_lo,
  input  logic [7:0]      ptr_hi,
  output cf_result_t      res
);

  localparam int REL_W  = 12;
  localparam int BR_W   = 7;
  localparam logic [PC_W-1:0] WRAP_MASK = {PC_W{1'b1}} >> (PC_W - PMEM_AW);

  logic [PC_W-1:0] seq1, seq2, rel_tgt, br_tgt, abs_tgt, ind_tgt;
  logic [PC_W-1:0] raw_next, raw_ret;
  logic            raw_push, raw_two;
  logic            tested_bit;

  assign seq1    = pc + PC_W'(1);
  assign seq2    = pc + PC_W'(2);
  assign rel_tgt = seq1 + {{(PC_W-REL_W){word0[REL_W-1]}}, word0[REL_W-1:0]};
  assign br_tgt  = seq1 + {{(PC_W-BR_W){word0[9]}}, word0[9:3]};
  assign abs_tgt = {word0[8:4], word0[0], word1};
  assign ind_tgt = {pc[PC_W-1:16], ptr_hi, ptr_lo};

  assign tested_bit = status[word0[2:0]];

  always_comb begin
    raw_next = seq1;
    raw_ret  = '0;
    raw_push = 1'b0;
    raw_two  = 1'b0;
    unique case (kind)
      K_REL_JUMP: raw_next = rel_tgt;
      K_REL_CALL: begin
        raw_next = rel_tgt;
        raw_push = 1'b1;
        raw_ret  = seq1;
      end
      K_BR_SET:   raw_next = tested_bit  ? br_tgt : seq1;
      K_BR_CLR:   raw_next = !tested_bit ? br_tgt : seq1;
      K_ABS_JUMP: begin
        raw_next = abs_tgt;
        raw_two  = 1'b1;
      end
      K_ABS_CALL: begin
        raw_next = abs_tgt;
        raw_two  = 1'b1;
        raw_push = 1'b1;
        raw_ret  = seq2;
      end
      K_IND_JUMP: raw_next = ind_tgt;
      K_IND_CALL: begin
        raw_next = ind_tgt;
        raw_push = 1'b1;
        raw_ret  = seq1;
      end
      default:    raw_next = seq1;
    endcase
  end

  assign res.next_pc  = raw_next & WRAP_MASK;
  assign res.ret_addr = raw_ret & WRAP_MASK;
  assign res.push     = raw_push;
  assign res.two_word = raw_two;

endmodule

// File: rtl/cf_out_stage.sv
module cf_out_stage
  import cf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  cf_result_t in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output cf_result_t out_data
);

  logic full_q;
  cf_result_t data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R9: a stalled beat is held
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8: acceptance yields a beat one cycle later
  a_r8_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

endmodule

// File: rtl/cf_next_pc.sv
module cf_next_pc
  import cf_pkg::*;
#(
  parameter int PMEM_AW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PC_W-1:0] in_pc,
  input  logic [15:0]     in_word0,
  input  logic [15:0]     in_word1,
  input  logic [7:0]      in_status,
  input  logic [7:0]      in_ptr_lo,
  input  logic [7:0]      in_ptr_hi,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_next_pc,
  output logic            out_push,
  output logic [PC_W-1:0] out_ret_addr,
  output logic            out_two_word
);

  localparam logic [PC_W-1:0] WRAP_MASK = {PC_W{1'b1}} >> (PC_W - PMEM_AW);

  cf_kind_e   kind;
  cf_result_t comb_res;
  cf_result_t reg_res;

  cf_decode u_decode (
    .word0 (in_word0),
    .kind  (kind)
  );

  cf_target #(.PMEM_AW(PMEM_AW)) u_target (
    .kind   (kind),
    .pc     (in_pc),
    .word0  (in_word0),
    .word1  (in_word1),
    .status (in_status),
    .ptr_lo (in_ptr_lo),
    .ptr_hi (in_ptr_hi),
    .res    (comb_res)
  );

  cf_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (reg_res)
  );

  assign out_next_pc  = reg_res.next_pc;
  assign out_push     = reg_res.push;
  assign out_ret_addr = reg_res.ret_addr;
  assign out_two_word = reg_res.two_word;

  // R7: nothing above the memory size escapes
  a_r7_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_next_pc & ~WRAP_MASK) == '0) && ((out_ret_addr & ~WRAP_MASK) == '0));

  // R5: a return address lies one or two words past the instruction
  a_r5_ret_offset: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && comb_res.push |->
      (comb_res.ret_addr == ((in_pc + PC_W'(1)) & WRAP_MASK)) ||
      (comb_res.ret_addr == ((in_pc + PC_W'(2)) & WRAP_MASK)));

  // R3: a two-word call returns past both words
  a_r3_two_word_ret: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && comb_res.two_word && comb_res.push |->
      comb_res.ret_addr == ((in_pc + PC_W'(2)) & WRAP_MASK));

  // R10: empty after reset
  a_r10_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/cf_next_pc_bench.sv
module cf_next_pc_bench;

  localparam int AW = 20;
  localparam int PW = 22;
  localparam logic [PW-1:0] MASK = (22'd1 << AW) - 22'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_pc = '0;
  logic [15:0]   in_word0 = '0, in_word1 = '0;
  logic [7:0]    in_status = '0, in_ptr_lo = '0, in_ptr_hi = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_next_pc, out_ret_addr;
  logic          out_push, out_two_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  cf_next_pc #(.PMEM_AW(AW)) u_cf_next_pc (
    .clk, .rst_n, .in_valid, .in_ready, .in_pc, .in_word0, .in_word1,
    .in_status, .in_ptr_lo, .in_ptr_hi, .out_valid, .out_ready,
    .out_next_pc, .out_push, .out_ret_addr, .out_two_word
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [PW-1:0] pc, input logic [15:0] w0, w1,
                                input logic [7:0] st, zl, zh,
                                output logic [PW-1:0] nxt, ret,
                                output logic push, two, output string req);
    logic [PW-1:0] s1 = pc + 22'd1;
    nxt = s1; ret = '0; push = 0; two = 0; req = "R6";
    if (w0[15:13] == 3'b110) begin
      nxt  = s1 + PW'($signed(w0[11:0]));
      push = w0[12];
      ret  = push ? s1 : '0;
      req  = push ? "R1/R5" : "R1";
    end else if (w0[15:11] == 5'b11110) begin
      req = "R2";
      if (st[w0[2:0]] != w0[10]) nxt = s1 + PW'($signed(w0[9:3]));
    end else if (w0 == 16'h9409 || w0 == 16'h9509) begin
      nxt  = {pc[21:16], zh, zl};
      push = w0[8];
      ret  = push ? s1 : '0;
      req  = "R4";
    end else if (w0[15:9] == 7'b1001010 && w0[3:2] == 2'b11) begin
      nxt  = {w0[8:4], w0[0], w1};
      two  = 1;
      push = w0[1];
      ret  = push ? pc + 22'd2 : '0;
      req  = "R3";
    end
    nxt &= MASK;
    ret &= MASK;
  endfunction

  task automatic apply(input logic [PW-1:0] pc, input logic [15:0] w0, w1,
                       input logic [7:0] st, zl, zh, input int stall);
    logic [PW-1:0] e_n, e_r;
    logic e_p, e_t;
    string rq;
    model(pc, w0, w1, st, zl, zh, e_n, e_r, e_p, e_t, rq);
    @(negedge clk);
    in_pc = pc; in_word0 = w0; in_word1 = w1;
    in_status = st; in_ptr_lo = zl; in_ptr_hi = zh;
    in_valid = 1'b1; out_ready = 1'b0;
    chk(in_ready == 1'b1, "R8", "in_ready empty", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
    chk(out_next_pc == e_n, rq, "next_pc", out_next_pc, e_n);
    chk(out_push == e_p && out_ret_addr == e_r, "R5", "push/ret",
        {out_push, out_ret_addr}, {e_p, e_r});
    chk(out_two_word == e_t, rq, "two_word", out_two_word, e_t);
    chk(((out_next_pc | out_ret_addr) & ~MASK) == 0, "R7", "upper bits",
        out_next_pc | out_ret_addr, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R8", "in_ready full", in_ready, 0);
      chk(out_valid && out_next_pc == e_n && out_push == e_p && out_ret_addr == e_r,
          "R9", "held beat", out_next_pc, e_n);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "drained", out_valid, 0);
    out_ready = 1'b0;
  endtask

  function automatic logic [15:0] rand_word(input int cls);
    logic [15:0] r = 16'($urandom);
    case (cls)
      0: return {3'b110, r[12:0]};
      1: return {5'b11110, r[10:0]};
      2: return {7'b1001010, r[8:4], 2'b11, r[1], r[0]};
      3: return r[0] ? 16'h9509 : 16'h9409;
      4: return {7'b1001010, r[8:4], 3'b100, r[0]};
      default: return r;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "after reset",
        {out_valid, in_ready}, 2'b01);
    // R1 extremes and wrap from PC 0
    apply(22'd0, 16'hC800, 0, 0, 0, 0, 0);
    apply(22'd100, 16'hD7FF, 0, 0, 0, 0, 2);
    apply(22'h0FFFFF, 16'hC000, 0, 0, 0, 0, 0);
    // R2 extremes, taken and not
    apply(22'd10, {6'b111100, 7'h3F, 3'd5}, 0, 8'h20, 0, 0, 0);
    apply(22'd10, {6'b111100, 7'h40, 3'd5}, 0, 8'hDF, 0, 0, 0);
    apply(22'd0, {6'b111101, 7'h40, 3'd0}, 0, 8'h00, 0, 0, 1);
    apply(22'd70, {6'b111101, 7'h40, 3'd7}, 0, 8'h80, 0, 0, 0);
    // R3 high bits outside memory, R4 keeps upper PC bits
    apply(22'h3FFFFF, 16'h95FF, 16'hABCD, 0, 0, 0, 0);
    apply(22'd5, 16'h940C, 16'h1234, 0, 0, 0, 0);
    apply(22'h0F1234, 16'h9409, 0, 0, 8'h78, 8'h56, 0);
    apply(22'h0AFFFF, 16'h9509, 0, 0, 8'hFF, 8'hFF, 3);
    // R6 neighbours
    apply(22'd42, 16'h0000, 0, 0, 0, 0, 0);
    apply(22'd42, 16'h9408, 0, 0, 0, 0, 0);
    apply(22'hFFFFF, 16'h9418, 0, 0, 0, 0, 0);
    for (int v = 0; v < 1500; v++) begin
      apply(PW'($urandom), rand_word(int'($urandom_range(0, 5))), 16'($urandom),
            8'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(0, 3)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule